// File: doc/BRIEF.md
# Multiply-Accumulate Execute Pipe with Dependency Interlock

This block is the multiply side of an in-order execute cluster. It accepts one instruction per cycle through a valid/ready issue port and holds a small register file. Add-type instructions finish in one cycle and retire through a fast write port. Multiply-type instructions go through a five-stage pipe. The first three stages form the 32-bit product. The fourth stage optionally adds an accumulate register. The fifth stage retires the result through a second write port.

A per-register busy scoreboard tracks destinations that an in-flight multiply still owes. An instruction is held at the issue port while any register it reads or writes is still owed. The register being written back in the current cycle is treated as free, because its value is forwarded. While an instruction waits, the multiply pipe keeps draining and bubbles flow downstream. Any result that is about to be written is forwarded to the operand reads, so a consumer may issue in the same cycle its producer retires.

Top module: `mac_pipe`

## Requirements
- R1: After reset both write-back ports are idle, `iss_ready` is high, and every register reads as zero.
- R2: Operation code 0 (add) writes rs1+rs2 and code 1 (add immediate) writes rs1+imm, both modulo 2^32. The result appears on the add write-back port in the cycle after acceptance.
- R3: Operation code 2 (multiply) writes the low 32 bits of rs1*rs2. The result appears on the multiply write-back port exactly five cycles after the acceptance cycle.
- R4: Operation code 3 (multiply-accumulate) writes the low 32 bits of rs1*rs2+ra, with the same latency as R3.
- R5: An instruction that reads a register still owed by an in-flight multiply is not accepted before the cycle in which that multiply is on the multiply write-back port. When it is presented in the cycle after the multiply is accepted, `iss_ready` is low for exactly four cycles.
- R6: An instruction accepted in the cycle its producer is on either write-back port computes with the new value.
- R7: An instruction whose destination is still owed by an in-flight multiply waits as in R5. The two write ports never target the same register in one cycle, and the younger value is what remains.
- R8: An instruction with no pending register is accepted in the cycle it is presented, including one that depends on an add accepted the cycle before.
- R9: Both write-back ports may fire in the same cycle, to different registers, and both values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| iss_valid | input | 1 | An instruction is presented |
| iss_ready | output | 1 | The presented instruction is accepted at this edge if valid |
| iss_op | input | 2 | 0 add, 1 add immediate, 2 multiply, 3 multiply-accumulate |
| iss_rd | input | 3 | Destination register |
| iss_rs1 | input | 3 | First source register |
| iss_rs2 | input | 3 | Second source register (unused by add immediate) |
| iss_ra | input | 3 | Accumulate source register (used only by code 3) |
| iss_imm | input | 32 | Immediate for add immediate |
| alu_wb_valid | output | 1 | Add result being written this cycle |
| alu_wb_rd | output | 3 | Register written by the add port |
| alu_wb_data | output | 32 | Value written by the add port |
| mul_wb_valid | output | 1 | Multiply result being written this cycle |
| mul_wb_rd | output | 3 | Register written by the multiply port |
| mul_wb_data | output | 32 | Value written by the multiply port |

## Verification
Add retirement and multiply retirement can fall in the same cycle. The clash is provoked by issuing a multiply followed by exactly four independent adds: the fourth add retires in the multiply's fifth-stage cycle. The bench watches both ports every cycle and compares each retired register and value against its own in-order model. It also checks that at least one such coincidence occurred and that the read-out values at the end still match the model. The issue interlock firing in that same retirement cycle is covered too: the bench predicts the exact stall count of every instruction from its own record of when each owed register frees up.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADDI = 2'd1,
    OP_MUL  = 2'd2,
    OP_MLA  = 2'd3
  } op_e;

  // stages a multiply occupies from issue+1 up to and including write-back
  localparam int MUL_DEPTH = 5;
endpackage

// File: rtl/mac_regfile.sv
module mac_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_a,
  input  logic [RW-1:0]   wa_a,
  input  logic [XLEN-1:0] wd_a,
  input  logic            we_b,
  input  logic [RW-1:0]   wa_b,
  input  logic [XLEN-1:0] wd_b,
  input  logic [RW-1:0]   ra_0,
  input  logic [RW-1:0]   ra_1,
  input  logic [RW-1:0]   ra_2,
  output logic [XLEN-1:0] rd_0,
  output logic [XLEN-1:0] rd_1,
  output logic [XLEN-1:0] rd_2
);
  logic [XLEN-1:0] mem [NREG];

  // read with forwarding of this cycle's write-back values
  function automatic logic [XLEN-1:0] rd_fwd(input logic [RW-1:0] a);
    if (we_b && wa_b == a)      return wd_b;
    else if (we_a && wa_a == a) return wd_a;
    else                        return mem[a];
  endfunction

  always_comb begin
    rd_0 = rd_fwd(ra_0);
    rd_1 = rd_fwd(ra_1);
    rd_2 = rd_fwd(ra_2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      if (we_a) mem[wa_a] <= wd_a;
      if (we_b) mem[wa_b] <= wd_b;
    end
  end

  AST_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && we_b) |-> (wa_a != wa_b)); // R7
endmodule

// File: rtl/mac_scoreboard.sv
module mac_scoreboard #(
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [RW-1:0] set_rd,
  input  logic          clr_en,
  input  logic [RW-1:0] clr_rd,
  input  logic [RW-1:0] q_rd,
  input  logic [RW-1:0] q_rs1,
  input  logic [RW-1:0] q_rs2,
  input  logic [RW-1:0] q_ra,
  input  logic          use_rs2,
  input  logic          use_ra,
  output logic          hazard
);
  logic [NREG-1:0] busy_q, busy_d;

  // a register retiring this cycle is forwarded, so it no longer blocks
  function automatic logic owed(input logic [RW-1:0] r);
    return busy_q[r] && !(clr_en && clr_rd == r);
  endfunction

  always_comb begin
    hazard = owed(q_rd) || owed(q_rs1) ||
             (use_rs2 && owed(q_rs2)) || (use_ra && owed(q_ra));
  end

  always_comb begin
    busy_d = busy_q;
    if (clr_en) busy_d[clr_rd] = 1'b0;
    if (set_en) busy_d[set_rd] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

  AST_RETIRE_WAS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> busy_q[clr_rd]); // R3
  AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy_q) <= mac_pkg::MUL_DEPTH); // R5
endmodule

// File: rtl/mac_mul_pipe.sv
module mac_mul_pipe #(
  parameter int XLEN = 32,
  parameter int RW = 3,
  localparam int HALF = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_acc_en,
  input  logic [RW-1:0]   in_rd,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [XLEN-1:0] in_c,
  output logic            out_valid,
  output logic [RW-1:0]   out_rd,
  output logic [XLEN-1:0] out_data
);
  // stage valid and control bits, index 1..5 used
  logic [5:1]      v_q;
  logic [RW-1:0]   rd_q  [5:1];
  logic [4:1]      acc_q;
  // data registers
  logic [XLEN-1:0] a1_q, b1_q, a2_q, b2_q;
  logic [XLEN-1:0] ll2_q, ll3_q, p4_q, r5_q;
  logic [HALF-1:0] cr3_q;
  logic [XLEN-1:0] c_q [4:1];

  // combinational work per stage
  logic [XLEN-1:0] ll_d, p_d, r_d;
  logic [HALF-1:0] cr_d;

  always_comb begin
    // E1: low halves product
    ll_d = {{HALF{1'b0}}, a1_q[HALF-1:0]} * {{HALF{1'b0}}, b1_q[HALF-1:0]};
    // E2: cross terms, only their low half reaches the result
    cr_d = a2_q[HALF-1:0] * b2_q[XLEN-1:HALF] + a2_q[XLEN-1:HALF] * b2_q[HALF-1:0];
    // E3: combine into the truncated product
    p_d  = ll3_q + {cr3_q, {HALF{1'b0}}};
    // E4: accumulate
    r_d  = p4_q + (acc_q[4] ? c_q[4] : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[4:1], in_valid};
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      rd_q[1] <= in_rd; acc_q[1] <= in_acc_en; c_q[1] <= in_c;
      a1_q <= in_a; b1_q <= in_b;
    end
    if (v_q[1]) begin
      rd_q[2] <= rd_q[1]; acc_q[2] <= acc_q[1]; c_q[2] <= c_q[1];
      ll2_q <= ll_d; a2_q <= a1_q; b2_q <= b1_q;
    end
    if (v_q[2]) begin
      rd_q[3] <= rd_q[2]; acc_q[3] <= acc_q[2]; c_q[3] <= c_q[2];
      ll3_q <= ll2_q; cr3_q <= cr_d;
    end
    if (v_q[3]) begin
      rd_q[4] <= rd_q[3]; acc_q[4] <= acc_q[3]; c_q[4] <= c_q[3];
      p4_q <= p_d;
    end
    if (v_q[4]) begin
      rd_q[5] <= rd_q[4];
      r5_q <= r_d;
    end
  end

  assign out_valid = v_q[5];
  assign out_rd    = rd_q[5];
  assign out_data  = r5_q;

  AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 5)); // R3
endmodule

// File: rtl/mac_pipe.sv
module mac_pipe #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  output logic            iss_ready,
  input  logic [1:0]      iss_op,
  input  logic [RW-1:0]   iss_rd,
  input  logic [RW-1:0]   iss_rs1,
  input  logic [RW-1:0]   iss_rs2,
  input  logic [RW-1:0]   iss_ra,
  input  logic [XLEN-1:0] iss_imm,
  output logic            alu_wb_valid,
  output logic [RW-1:0]   alu_wb_rd,
  output logic [XLEN-1:0] alu_wb_data,
  output logic            mul_wb_valid,
  output logic [RW-1:0]   mul_wb_rd,
  output logic [XLEN-1:0] mul_wb_data
);
  import mac_pkg::*;

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  op_e             op;
  logic            is_mul, use_rs2, use_ra, hazard, fire;
  logic [XLEN-1:0] opa, opb, opc;

  assign op      = op_e'(iss_op);
  assign is_mul  = (op == OP_MUL) || (op == OP_MLA);
  assign use_rs2 = (op != OP_ADDI);
  assign use_ra  = (op == OP_MLA);
  assign iss_ready = !hazard;
  assign fire    = iss_valid && !hazard;

  mac_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_s_n),
    .we_a(mul_wb_valid), .wa_a(mul_wb_rd), .wd_a(mul_wb_data),
    .we_b(alu_wb_valid), .wa_b(alu_wb_rd), .wd_b(alu_wb_data),
    .ra_0(iss_rs1), .ra_1(iss_rs2), .ra_2(iss_ra),
    .rd_0(opa), .rd_1(opb), .rd_2(opc)
  );

  mac_scoreboard #(.NREG(NREG)) u_sb (
    .clk(clk), .rst_n(rst_s_n),
    .set_en(fire && is_mul), .set_rd(iss_rd),
    .clr_en(mul_wb_valid), .clr_rd(mul_wb_rd),
    .q_rd(iss_rd), .q_rs1(iss_rs1), .q_rs2(iss_rs2), .q_ra(iss_ra),
    .use_rs2(use_rs2), .use_ra(use_ra), .hazard(hazard)
  );

  mac_mul_pipe #(.XLEN(XLEN), .RW(RW)) u_mul (
    .clk(clk), .rst_n(rst_s_n),
    .in_valid(fire && is_mul), .in_acc_en(use_ra), .in_rd(iss_rd),
    .in_a(opa), .in_b(opb), .in_c(opc),
    .out_valid(mul_wb_valid), .out_rd(mul_wb_rd), .out_data(mul_wb_data)
  );

  // single-cycle add path with one write-back register
  logic            aw_v_q, aw_v_d, aw_en;
  logic [RW-1:0]   aw_rd_q;
  logic [XLEN-1:0] aw_d_q, aw_sum;

  always_comb begin
    aw_v_d = fire && !is_mul;
    aw_en  = aw_v_d;
    aw_sum = opa + ((op == OP_ADDI) ? iss_imm : opb);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) aw_v_q <= 1'b0;
    else          aw_v_q <= aw_v_d;
  end

  always_ff @(posedge clk) begin
    if (aw_en) begin
      aw_rd_q <= iss_rd;
      aw_d_q  <= aw_sum;
    end
  end

  assign alu_wb_valid = aw_v_q;
  assign alu_wb_rd    = aw_rd_q;
  assign alu_wb_data  = aw_d_q;

  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (iss_valid && !iss_ready) |=> !alu_wb_valid); // R5
  AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_s_n)
    (alu_wb_valid && mul_wb_valid) |-> (alu_wb_rd != mul_wb_rd)); // R7
endmodule

// File: tb/sim_mac_pipe.sv
module sim_mac_pipe;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid;
  logic        iss_ready;
  logic [1:0]  iss_op;
  logic [2:0]  iss_rd, iss_rs1, iss_rs2, iss_ra;
  logic [31:0] iss_imm;
  logic        alu_wb_valid, mul_wb_valid;
  logic [2:0]  alu_wb_rd, mul_wb_rd;
  logic [31:0] alu_wb_data, mul_wb_data;

  always #10 clk = ~clk;

  mac_pipe u0 (.*);

  int n_chk = 0, n_fail = 0, both_cnt = 0, cyc = 0;
  bit mon_en = 0, done = 0;
  logic [31:0] m [8];
  int ready_at [8];
  logic [2:0]  aq_rd[$], mq_rd[$];
  logic [31:0] aq_d[$],  mq_d[$];
  string       aq_tag[$], mq_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // write-back monitor against the in-order model
  always @(negedge clk) if (mon_en) begin
    if (alu_wb_valid && mul_wb_valid) both_cnt++;
    if (alu_wb_valid) begin
      if (aq_d.size() == 0) chk("R2 unexpected add write", 32'd1, 32'd0);
      else begin
        chk({aq_tag[0], " add rd"}, {29'd0, alu_wb_rd}, {29'd0, aq_rd[0]});
        chk({aq_tag[0], " add data"}, alu_wb_data, aq_d[0]);
        void'(aq_rd.pop_front()); void'(aq_d.pop_front()); void'(aq_tag.pop_front());
      end
    end
    if (mul_wb_valid) begin
      if (mq_d.size() == 0) chk("R3 unexpected mul write", 32'd1, 32'd0);
      else begin
        chk({mq_tag[0], " mul rd"}, {29'd0, mul_wb_rd}, {29'd0, mq_rd[0]});
        chk({mq_tag[0], " mul data"}, mul_wb_data, mq_d[0]);
        void'(mq_rd.pop_front()); void'(mq_d.pop_front()); void'(mq_tag.pop_front());
      end
    end
  end

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // present one instruction, wait for acceptance, predict stall and result
  task automatic issue(input logic [1:0] op, input logic [2:0] rd, input logic [2:0] rs1,
                       input logic [2:0] rs2, input logic [2:0] ra, input logic [31:0] imm,
                       input string tag);
    int present, exp_at, stalls;
    logic [31:0] res;
    @(negedge clk);
    iss_valid = 1; iss_op = op; iss_rd = rd; iss_rs1 = rs1;
    iss_rs2 = rs2; iss_ra = ra; iss_imm = imm;
    present = cyc;
    exp_at = imax(present, imax(ready_at[rd], ready_at[rs1]));
    if (op != 2'd1) exp_at = imax(exp_at, ready_at[rs2]);
    if (op == 2'd3) exp_at = imax(exp_at, ready_at[ra]);
    stalls = 0;
    forever begin
      #1;
      if (iss_ready) break;
      stalls++;
      @(negedge clk);
    end
    chk((exp_at > present) ? "R5/R7 stall count" : "R8 no stall", stalls, exp_at - present);
    case (op)
      2'd0: res = m[rs1] + m[rs2];
      2'd1: res = m[rs1] + imm;
      2'd2: res = m[rs1] * m[rs2];
      default: res = m[rs1] * m[rs2] + m[ra];
    endcase
    if (op[1]) begin
      mq_rd.push_back(rd); mq_d.push_back(res); mq_tag.push_back(tag);
      ready_at[rd] = cyc + 5;
    end else begin
      aq_rd.push_back(rd); aq_d.push_back(res); aq_tag.push_back(tag);
    end
    m[rd] = res;
    @(posedge clk); #1;
    iss_valid = 0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    finish_up();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin m[i] = '0; ready_at[i] = 0; end
    rst_n = 0; iss_valid = 0; iss_op = 0; iss_rd = 0; iss_rs1 = 0;
    iss_rs2 = 0; iss_ra = 0; iss_imm = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 add port idle in reset", {31'd0, alu_wb_valid}, 32'd0);
    chk("R1 mul port idle in reset", {31'd0, mul_wb_valid}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", {31'd0, iss_ready}, 32'd1);
    chk("R1 add port idle", {31'd0, alu_wb_valid}, 32'd0);
    chk("R1 mul port idle", {31'd0, mul_wb_valid}, 32'd0);
    mon_en = 1;

    // R1: every register reads zero
    for (int r = 0; r < 8; r++) issue(2'd1, 3'(r), 3'(r), 3'd0, 3'd0, 32'd0, "R1 zero");

    // operand setup
    issue(2'd1, 3'd1, 3'd0, 3'd0, 3'd0, 32'hFFFF_FFFF, "R2 addi");
    issue(2'd1, 3'd2, 3'd0, 3'd0, 3'd0, 32'h1234_5678, "R2 addi");
    issue(2'd1, 3'd3, 3'd0, 3'd0, 3'd0, 32'h9ABC_DEF0, "R2 addi");
    issue(2'd0, 3'd4, 3'd1, 3'd2, 3'd0, 32'd0, "R8 add on fresh add result");
    // R3: all-ones squared, R4 with accumulate, then R5/R6 dependent add
    issue(2'd2, 3'd5, 3'd1, 3'd1, 3'd0, 32'd0, "R3 mul");
    issue(2'd0, 3'd6, 3'd5, 3'd2, 3'd0, 32'd0, "R6 forwarded product");
    issue(2'd3, 3'd7, 3'd2, 3'd3, 3'd4, 32'd0, "R4 mla");
    issue(2'd0, 3'd0, 3'd7, 3'd7, 3'd0, 32'd0, "R6 forwarded mla");
    // R7: add to the same destination as an in-flight multiply
    issue(2'd2, 3'd6, 3'd2, 3'd3, 3'd0, 32'd0, "R7 older mul");
    issue(2'd1, 3'd6, 3'd1, 3'd0, 3'd0, 32'd5, "R7 younger add");
    issue(2'd1, 3'd0, 3'd6, 3'd0, 3'd0, 32'd0, "R7 survivor");
    // R9: multiply then four independent adds, the last retires with it
    issue(2'd2, 3'd5, 3'd2, 3'd2, 3'd0, 32'd0, "R9 mul");
    issue(2'd1, 3'd1, 3'd1, 3'd0, 3'd0, 32'd1, "R9 add");
    issue(2'd1, 3'd2, 3'd2, 3'd0, 3'd0, 32'd2, "R9 add");
    issue(2'd1, 3'd3, 3'd3, 3'd0, 3'd0, 32'd3, "R9 add");
    issue(2'd0, 3'd4, 3'd1, 3'd3, 3'd0, 32'd0, "R9 add");
    // dependent two slots behind a multiply: stall of three
    issue(2'd2, 3'd7, 3'd1, 3'd2, 3'd0, 32'd0, "R3 mul");
    issue(2'd1, 3'd0, 3'd1, 3'd0, 3'd0, 32'd9, "R8 independent");
    issue(2'd3, 3'd6, 3'd1, 3'd2, 3'd7, 32'd0, "R5 accumulate dependent");
    drain();
    chk("R9 both ports fired together", (both_cnt > 0) ? 32'd1 : 32'd0, 32'd1);

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      issue(op, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
            3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
            $urandom(), op[1] ? (op[0] ? "R4 rnd" : "R3 rnd") : "R2 rnd");
    end
    drain();
    for (int r = 0; r < 8; r++) issue(2'd1, 3'(r), 3'(r), 3'd0, 3'd0, 32'd0, "R7 final readout");
    drain();
    chk("R3 no result left owed", mq_d.size() + aq_d.size(), 32'd0);
    finish_up();
  end
endmodule